// File: doc/BRIEF.md
# DMA Channel Programming Register File

This block holds the programming state of a four-channel DMA controller and exposes it on a narrow 8-bit I/O bus. The host uses a 16-byte port window. Each channel has a 16-bit start address and a 16-bit transfer count. Both are moved over the bus one byte at a time, and a single byte pointer, shared by all channels, decides which half each access hits. The window also holds:

- per-channel mode and mask controls;
- a command byte;
- a few "strobe" ports whose write data is ignored.

The stored values are driven out as flat vectors for a separate transfer engine. That engine reports channel completions back on `tcIn`. Those completions collect as sticky flags in a status byte, and the flags clear when the status byte is read.

Reads are combinational. While `ioRd` is high, `ioRdData` shows the selected byte. Every side effect of an access lands on the rising edge that ends it:

- the pointer toggles;
- the status flags clear;
- the register is loaded.

Top module: `dmaChanRegs`

## Requirements
- R1: After reset, all four mask bits are 1. All address, count, mode and command values are 0, the status flags are clear, and the byte pointer selects the low byte.
- R2: The address of channel n sits at port offset 2n and its count at offset 2n+1. Two successive writes load the low byte and then the high byte, and the new value appears on `baseAddr`/`baseCount` slice n after the write edge.
- R3: A single byte pointer is shared by all channels and by both address and count. Every read or write of offsets 0x0..0x7 flips it, so consecutive accesses to different registers alternate between low and high bytes.
- R4: A write of any value to offset 0xC returns the byte pointer to the low byte.
- R5: A read of offsets 0x0..0x7 returns the stored byte chosen by the byte pointer. It follows the same low/high sequence as writes, and reads and writes may be interleaved.
- R6: A write to offset 0xA selects a channel with data bits 1:0. Data bit 2 = 1 sets that channel's mask bit, and 0 clears it. The other mask bits are untouched.
- R7: A write to offset 0xB selects a channel with data bits 1:0 and stores data bits 7:2 as that channel's 6-bit mode (`chanMode` slice n).
  - Mode bits 1:0 are the direction: 01 means into memory, 10 means from memory.
  - Mode bit 2 is auto-initialize.
  - Mode bits 5:4 are the transfer kind: 01 single, 11 cascade.
  - Other channels' modes are untouched.
- R8: A write to offset 0xE clears all mask bits. A write to offset 0xF loads the mask bits from data bits 3:0, and data bits 7:4 are ignored.
- R9: A write to offset 0xD performs a master clear. It sets all mask bits, returns the byte pointer to low, and clears the modes, the command byte and the status flags. Address and count values are kept.
- R10: A write to offset 0x8 stores the command byte on `cmdReg`. A read of offset 0x8 returns the four status flags in bits 3:0 and zero in bits 7:4, and clears the flags at the end of the read. A `tcIn` pulse in that same cycle still sets its flag.
- R11: A pulse on `tcIn[n]` sets status flag n, and the flag stays set until a status read or a master clear.
- R12: Reads of offset 0xD and of any other offset above 0x7 except 0x8 return 0 and do not move the byte pointer. A write to offset 0x9 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ioAddr | input | 4 | Port offset within the window |
| ioWrData | input | 8 | Write data byte |
| ioWr | input | 1 | Write strobe, one access per cycle high |
| ioRd | input | 1 | Read strobe, ignored while ioWr is high |
| ioRdData | output | 8 | Read data, combinational while ioRd is high, 0 otherwise |
| tcIn | input | 4 | Per-channel terminal-count pulses from the transfer engine |
| baseAddr | output | 64 | Channel n address in bits 16n+15:16n |
| baseCount | output | 64 | Channel n count in bits 16n+15:16n |
| chanMode | output | 24 | Channel n mode in bits 6n+5:6n |
| chanMask | output | 4 | Mask bit per channel, 1 = masked |
| cmdReg | output | 8 | Last command byte written |

## Verification
Read data is due in the same cycle as the read strobe. The bench samples `ioRdData` in the middle of the low clock phase, before the edge that moves the pointer or clears the flags. Register, mask, mode, command and pointer effects are due one rising edge after the access. The bench drives every access at a falling edge, removes it at the next falling edge, and only then compares the outputs. Pointer position is never read directly: it is inferred from which byte a following access lands in or returns.

// File: rtl/dmaRegPkg.sv
package dmaRegPkg;
  localparam int CH_NUM  = 4;
  localparam int CH_W    = $clog2(CH_NUM);
  localparam int BUS_W   = 8;
  localparam int REG_W   = 16;
  localparam int MODE_W  = BUS_W - CH_W;
  localparam int ADDR_W  = 4;
  localparam int TC_W    = CH_NUM;

  localparam logic [ADDR_W-1:0] OFS_CMD     = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_REQ     = 4'h9;
  localparam logic [ADDR_W-1:0] OFS_MASKONE = 4'hA;
  localparam logic [ADDR_W-1:0] OFS_MODE    = 4'hB;
  localparam logic [ADDR_W-1:0] OFS_FFCLR   = 4'hC;
  localparam logic [ADDR_W-1:0] OFS_MCLR    = 4'hD;
  localparam logic [ADDR_W-1:0] OFS_UNMASK  = 4'hE;
  localparam logic [ADDR_W-1:0] OFS_MASKALL = 4'hF;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_REG  = 2'd1,
    RD_STAT = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic            regWr;
    logic            regRd;
    logic            isCount;
    logic [CH_W-1:0] ch;
    logic            hiByte;
    logic            modeWr;
    logic            maskOneWr;
    logic            maskAllWr;
    logic            maskClr;
    logic            masterClr;
    logic            cmdWr;
    logic            statRd;
    rdSel_e          rdSel;
  } strobe_t;
endpackage

// File: rtl/dmaRegCtrl.sv
module dmaRegCtrl
  import dmaRegPkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ioAddr,
  input  logic          ioWr,
  input  logic          ioRd,
  output strobe_t       stb
);
  logic bytePtr;
  logic ffClr;
  logic inRegWin;
  logic rdEn;

  assign inRegWin = ~ioAddr[AW-1];
  assign rdEn     = ioRd & ~ioWr;

  always_comb begin
    stb         = '0;
    ffClr       = 1'b0;
    stb.ch      = ioAddr[CH_W:1];
    stb.isCount = ioAddr[0];
    stb.hiByte  = bytePtr;
    stb.regWr   = ioWr & inRegWin;
    stb.regRd   = rdEn & inRegWin;
    stb.rdSel   = RD_ZERO;
    if (ioWr && !inRegWin) begin
      case (ioAddr)
        OFS_CMD:     stb.cmdWr     = 1'b1;
        OFS_MASKONE: stb.maskOneWr = 1'b1;
        OFS_MODE:    stb.modeWr    = 1'b1;
        OFS_FFCLR:   ffClr         = 1'b1;
        OFS_MCLR:    stb.masterClr = 1'b1;
        OFS_UNMASK:  stb.maskClr   = 1'b1;
        OFS_MASKALL: stb.maskAllWr = 1'b1;
        default:     ;
      endcase
    end
    if (rdEn) begin
      if (inRegWin) begin
        stb.rdSel = RD_REG;
      end else if (ioAddr == OFS_CMD) begin
        stb.rdSel  = RD_STAT;
        stb.statRd = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytePtr <= 1'b0;
    end else if (ffClr || stb.masterClr) begin
      bytePtr <= 1'b0;
    end else if (stb.regWr || stb.regRd) begin
      bytePtr <= ~bytePtr;
    end
  end

  // R2
  one_write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.regWr, stb.cmdWr, stb.maskOneWr, stb.modeWr, ffClr,
              stb.masterClr, stb.maskClr, stb.maskAllWr}));

  // R3
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stb.regWr || stb.regRd) && !ffClr && !stb.masterClr)
      |=> (bytePtr != $past(bytePtr)));

  // R4
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ffClr |=> !bytePtr);

  // R12
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ioWr && ioRd && !inRegWin) |=> $stable(bytePtr));
endmodule

// File: rtl/dmaRegPath.sv
module dmaRegPath
  import dmaRegPkg::*;
#(
  parameter int NCH = CH_NUM,
  parameter int BW  = BUS_W,
  parameter int RW  = REG_W,
  parameter int MW  = MODE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  strobe_t         stb,
  input  logic [BW-1:0]   wrData,
  input  logic [NCH-1:0]  tcIn,
  output logic [BW-1:0]   rdData,
  output logic [NCH*RW-1:0] baseAddr,
  output logic [NCH*RW-1:0] baseCount,
  output logic [NCH*MW-1:0] chanMode,
  output logic [NCH-1:0]  chanMask,
  output logic [BW-1:0]   cmdReg
);
  localparam int HALF = RW / 2;

  logic [RW-1:0]  addrReg [NCH];
  logic [RW-1:0]  cntReg  [NCH];
  logic [MW-1:0]  modeReg [NCH];
  logic [NCH-1:0] maskReg;
  logic [NCH-1:0] tcFlags;
  logic [BW-1:0]  cmdQ;
  logic [CH_W-1:0] dataCh;
  logic [RW-1:0]  selWord;
  logic [BW-1:0]  selByte;

  assign dataCh = wrData[CH_W-1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic hitAddr;
    logic hitCnt;
    assign hitAddr = stb.regWr && !stb.isCount && (stb.ch == CH_W'(g));
    assign hitCnt  = stb.regWr &&  stb.isCount && (stb.ch == CH_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addrReg[g] <= '0;
      end else if (hitAddr) begin
        if (stb.hiByte) addrReg[g][RW-1:HALF] <= wrData;
        else            addrReg[g][HALF-1:0]  <= wrData;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cntReg[g] <= '0;
      end else if (hitCnt) begin
        if (stb.hiByte) cntReg[g][RW-1:HALF] <= wrData;
        else            cntReg[g][HALF-1:0]  <= wrData;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        modeReg[g] <= '0;
      end else if (stb.masterClr) begin
        modeReg[g] <= '0;
      end else if (stb.modeWr && dataCh == CH_W'(g)) begin
        modeReg[g] <= wrData[BW-1:CH_W];
      end
    end

    assign baseAddr [g*RW +: RW] = addrReg[g];
    assign baseCount[g*RW +: RW] = cntReg[g];
    assign chanMode [g*MW +: MW] = modeReg[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskReg <= '1;
    end else if (stb.masterClr) begin
      maskReg <= '1;
    end else if (stb.maskClr) begin
      maskReg <= '0;
    end else if (stb.maskAllWr) begin
      maskReg <= wrData[NCH-1:0];
    end else if (stb.maskOneWr) begin
      maskReg[dataCh] <= wrData[CH_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdQ <= '0;
    end else if (stb.masterClr) begin
      cmdQ <= '0;
    end else if (stb.cmdWr) begin
      cmdQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcFlags <= '0;
    end else if (stb.masterClr) begin
      tcFlags <= '0;
    end else begin
      tcFlags <= (stb.statRd ? '0 : tcFlags) | tcIn;
    end
  end

  always_comb begin
    selWord = stb.isCount ? cntReg[stb.ch] : addrReg[stb.ch];
    selByte = stb.hiByte ? selWord[RW-1:HALF] : selWord[HALF-1:0];
    case (stb.rdSel)
      RD_REG:  rdData = selByte;
      RD_STAT: rdData = BW'(tcFlags);
      default: rdData = '0;
    endcase
  end

  assign chanMask = maskReg;
  assign cmdReg   = cmdQ;

  // R9
  master_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.masterClr |=> (maskReg == '1 && tcFlags == '0 && cmdQ == '0));

  // R8
  unmask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.maskClr && !stb.masterClr) |=> (maskReg == '0));

  // R10
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.statRd && tcIn == '0) |=> (tcFlags == '0));

  // R11
  tc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.masterClr && !stb.statRd) |=> ((tcFlags & $past(tcFlags)) == $past(tcFlags)));
endmodule

// File: rtl/dmaChanRegs.sv
module dmaChanRegs
  import dmaRegPkg::*;
#(
  parameter int NCH = CH_NUM,
  parameter int AW  = ADDR_W,
  parameter int BW  = BUS_W,
  parameter int RW  = REG_W,
  parameter int MW  = MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     ioAddr,
  input  logic [BW-1:0]     ioWrData,
  input  logic              ioWr,
  input  logic              ioRd,
  output logic [BW-1:0]     ioRdData,
  input  logic [NCH-1:0]    tcIn,
  output logic [NCH*RW-1:0] baseAddr,
  output logic [NCH*RW-1:0] baseCount,
  output logic [NCH*MW-1:0] chanMode,
  output logic [NCH-1:0]    chanMask,
  output logic [BW-1:0]     cmdReg
);
  strobe_t stb;

  dmaRegCtrl #(.AW(AW)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .ioAddr (ioAddr),
    .ioWr   (ioWr),
    .ioRd   (ioRd),
    .stb    (stb)
  );

  dmaRegPath #(.NCH(NCH), .BW(BW), .RW(RW), .MW(MW)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .wrData    (ioWrData),
    .tcIn      (tcIn),
    .rdData    (ioRdData),
    .baseAddr  (baseAddr),
    .baseCount (baseCount),
    .chanMode  (chanMode),
    .chanMask  (chanMask),
    .cmdReg    (cmdReg)
  );
endmodule

// File: tb/dmaChanRegs_bench.sv
`timescale 1ns/1ps
module dmaChanRegs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ioAddr = '0;
  logic [7:0]  ioWrData = '0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [7:0]  ioRdData;
  logic [3:0]  tcIn = '0;
  logic [63:0] baseAddr;
  logic [63:0] baseCount;
  logic [23:0] chanMode;
  logic [3:0]  chanMask;
  logic [7:0]  cmdReg;

  int checkCnt = 0;
  int failCnt  = 0;

  always #10 clk = ~clk;

  dmaChanRegs u_dmaChanRegs (
    .clk(clk), .rst_n(rst_n), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioWr(ioWr), .ioRd(ioRd), .ioRdData(ioRdData), .tcIn(tcIn),
    .baseAddr(baseAddr), .baseCount(baseCount), .chanMode(chanMode),
    .chanMask(chanMask), .cmdReg(cmdReg)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ioWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic ioRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1;
    #5 d = ioRdData;
    @(negedge clk);
    ioRd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 mask", chanMask, 64'hF);
    check("R1 addr", baseAddr, 0);
    check("R1 count", baseCount, 0);
    check("R1 mode", chanMode, 0);
    check("R1 cmd", cmdReg, 0);
    ioRead(4'h8, d);
    check("R1 status", d, 0);
    ioWrite(4'h0, 8'hAB);
    check("R1 pointer starts low", baseAddr[15:0], 16'h00AB);
  endtask

  task automatic t_load();
    ioWrite(4'hC, 8'h00);
    ioWrite(4'h0, 8'h34); ioWrite(4'h0, 8'h12);
    check("R2 ch0 addr", baseAddr[15:0], 16'h1234);
    ioWrite(4'h5, 8'hCD); ioWrite(4'h5, 8'hAB);
    check("R2 ch2 count", baseCount[47:32], 16'hABCD);
    ioWrite(4'h6, 8'h78); ioWrite(4'h6, 8'h56);
    check("R2 ch3 addr", baseAddr[63:48], 16'h5678);
  endtask

  task automatic t_shared();
    ioWrite(4'hC, 8'h00);
    ioWrite(4'h0, 8'h11);
    ioWrite(4'h3, 8'h22);
    check("R3 ch0 addr low", baseAddr[15:0], 16'h1211);
    check("R3 ch1 count high", baseCount[31:16], 16'h2200);
  endtask

  task automatic t_ffClear();
    ioWrite(4'hC, 8'h00);
    ioWrite(4'h0, 8'h99);
    ioWrite(4'hC, 8'h5A);
    ioWrite(4'h0, 8'h77);
    check("R4 pointer back to low", baseAddr[15:0], 16'h1277);
  endtask

  task automatic t_readBack();
    logic [7:0] d;
    ioWrite(4'hC, 8'h00);
    ioRead(4'h5, d); check("R5 count low", d, 8'hCD);
    ioRead(4'h5, d); check("R5 count high", d, 8'hAB);
    ioRead(4'h0, d); check("R5 addr low", d, 8'h77);
    ioWrite(4'h0, 8'h44);
    check("R5 read then write hits high", baseAddr[15:0], 16'h4477);
  endtask

  task automatic t_mask();
    ioWrite(4'hE, 8'hFF);
    check("R8 clear all masks", chanMask, 4'h0);
    ioWrite(4'hA, 8'h06);
    check("R6 set ch2", chanMask, 4'h4);
    ioWrite(4'hA, 8'h07);
    check("R6 set ch3", chanMask, 4'hC);
    ioWrite(4'hA, 8'h02);
    check("R6 clear ch2", chanMask, 4'h8);
    ioWrite(4'hF, 8'hA5);
    check("R8 load all masks", chanMask, 4'h5);
  endtask

  task automatic t_mode();
    ioWrite(4'hB, 8'h56);
    check("R7 ch2 mode", chanMode[17:12], 6'h15);
    check("R7 others untouched", {chanMode[23:18], chanMode[11:0]}, 0);
    ioWrite(4'hB, 8'hD3);
    check("R7 ch3 mode", chanMode[23:18], 6'h34);
    check("R7 ch2 kept", chanMode[17:12], 6'h15);
  endtask

  task automatic t_status();
    logic [7:0] d;
    @(negedge clk); tcIn = 4'b0101;
    @(negedge clk); tcIn = 4'b0000;
    repeat (2) @(negedge clk);
    ioRead(4'h8, d); check("R11 flags sticky", d, 8'h05);
    ioRead(4'h8, d); check("R10 read clears", d, 8'h00);
    @(negedge clk);
    ioAddr = 4'h8; ioRd = 1'b1; tcIn = 4'b1000;
    #5 d = ioRdData;
    @(negedge clk);
    ioRd = 1'b0; tcIn = 4'b0000;
    check("R10 read shows old flags", d, 8'h00);
    ioRead(4'h8, d); check("R10 same-cycle pulse kept", d, 8'h08);
    ioWrite(4'h8, 8'h3C);
    check("R10 command byte", cmdReg, 8'h3C);
  endtask

  task automatic t_ignored();
    logic [7:0] d;
    ioWrite(4'hC, 8'h00);
    ioRead(4'hD, d); check("R12 temp reads zero", d, 8'h00);
    ioRead(4'h9, d); check("R12 req reads zero", d, 8'h00);
    ioRead(4'h0, d); check("R12 pointer not moved", d, 8'h77);
    ioWrite(4'h9, 8'hFF);
    check("R12 req write mask", chanMask, 4'h5);
    check("R12 req write cmd", cmdReg, 8'h3C);
    ioWrite(4'hC, 8'h00);
    ioRead(4'h0, d);
    ioRead(4'h0, d); check("R12 regs intact", d, 8'h44);
  endtask

  task automatic t_master();
    logic [7:0] d;
    @(negedge clk); tcIn = 4'b0001;
    @(negedge clk); tcIn = 4'b0000;
    ioWrite(4'hE, 8'h00);
    ioWrite(4'hC, 8'h00);
    ioWrite(4'h2, 8'h10);
    ioWrite(4'hD, 8'h00);
    check("R9 masks set", chanMask, 4'hF);
    check("R9 modes clear", chanMode, 0);
    check("R9 cmd clear", cmdReg, 0);
    check("R9 addr kept", baseAddr[15:0], 16'h4477);
    ioRead(4'h8, d); check("R9 status clear", d, 8'h00);
    ioWrite(4'h2, 8'h20);
    check("R9 pointer low", baseAddr[31:16], 16'h0020);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_shared();
    t_ffClear();
    t_readBack();
    t_mask();
    t_mode();
    t_status();
    t_ignored();
    t_master();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule